// File: doc/BRIEF.md
# Lock-Aware Round-Robin Victim Selector

This block picks the way to overwrite when a line is brought into a 32-set, 32-way instruction cache. Every set has two pieces of state: how many of its ways are pinned (locked), and a round-robin pointer. Pinned ways always form a contiguous group that starts at way 0. A request names a set and says whether it is an ordinary fill or a locking fill. A locking fill takes the next way above the pinned group and makes the group one way larger. An ordinary fill takes the way the pointer shows and then advances the pointer. When the pointer passes the top way, it wraps back to the bottom of the unpinned range, so pinned ways are never chosen for replacement.

Requests enter through a valid/ready handshake. A request is accepted in any cycle where both `req_valid` and `req_ready` are high. The result comes out one cycle later through a second valid/ready pair. A result stays held until the consumer raises `vic_ready`. While a result is held and not being taken, `req_ready` stays low, so nothing is lost. A locking fill that finds the pinned group already at its limit produces no result. Instead it pulses `lock_err`. The `inval` input is a plain control pin. It unpins every way and returns every pointer to way 0. It wins over any request in the same cycle.

Top module: `victim_sel`

## Requirements
- R1: After reset, `vic_valid` and `lock_err` are 0 and `req_ready` is 1. Every set starts with no pinned ways and its pointer at way 0.
- R2: A locking fill (`req_lock`=1) on a set returns `vic_way` equal to that set's pinned count and raises the count by one. Successive locking fills on one set therefore return 0, 1, 2, and so on.
- R3: No more than 28 ways of a set can be pinned, so a locking fill always returns a way below 28. A locking fill on a set that already has 28 pinned ways gives a one-cycle `lock_err` pulse, produces no result, and leaves that set's state unchanged.
- R4: An ordinary fill (`req_lock`=0) returns the set's pointer and advances it by one. A set with nothing pinned returns 0, 1, ..., 31 and then 0 again.
- R5: In a set with N pinned ways, the pointer wraps from way 31 to way N, not to way 0.
- R6: If an ordinary fill finds the pointer below the pinned count, the pointer is first raised to the pinned count. That way is returned, and the pointer then continues from it.
- R7: Every set keeps its own pinned count and pointer. A request changes only the set named by `req_set`.
- R8: While `inval` is high, `req_ready` is 0. On that edge every pinned count and every pointer returns to 0.
- R9: An accepted request produces exactly one of two outcomes in the next cycle: `vic_valid` rises with the chosen way, or `lock_err` pulses.
- R10: While `vic_valid` is 1 and `vic_ready` is 0, `vic_way` and `vic_lock` hold steady and `req_ready` is 0.
- R11: `vic_lock` is 1 on a result from a locking fill and 0 on a result from an ordinary fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inval | input | 1 | Clears all pinned counts and pointers; blocks requests |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_set | input | 5 | Set index of the request |
| req_lock | input | 1 | 1 = locking fill, 0 = ordinary fill |
| vic_valid | output | 1 | Result held on the output |
| vic_ready | input | 1 | Consumer takes the result this cycle |
| vic_way | output | 5 | Chosen way |
| vic_lock | output | 1 | Result came from a locking fill |
| lock_err | output | 1 | One-cycle pulse: locking fill refused at the 28-way limit |

## Verification
The properties assume a synchronous reset and inputs that change only between clock edges. They also assume that `req_set`, `req_lock` and `vic_ready` are driven to known values whenever they matter. None of them assumes that `req_valid` stays up while it is waiting. The bench changes its inputs only between clock edges. It holds each request until `req_ready` lets it in, and it drops `vic_ready` only for a stretch it checks explicitly. All sets indices are in range by width. The bench also raises `inval` together with a pending request to show that the clear wins over the request.

// File: rtl/vs_pkg.sv
package vs_pkg;
  typedef enum logic {
    VS_FILL = 1'b0,
    VS_LOCK = 1'b1
  } vs_kind_e;
endpackage

// File: rtl/vs_state_table.sv
// Per-set pinned count and round-robin pointer, one read and one write port.
module vs_state_table #(
  parameter int NUM_SETS = 32,
  parameter int WAY_W    = 5,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_cnt,
  output logic [WAY_W-1:0] rd_ptr,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_cnt,
  input  logic [WAY_W-1:0] wr_ptr
);
  logic [WAY_W-1:0] cnt_q [NUM_SETS];
  logic [WAY_W-1:0] ptr_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic hit;
    assign hit = wr_en && (wr_set == SET_W'(s));
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        cnt_q[s] <= '0;
        ptr_q[s] <= '0;
      end else if (hit) begin
        cnt_q[s] <= wr_cnt;
        ptr_q[s] <= wr_ptr;
      end
    end
  end

  assign rd_cnt = cnt_q[rd_set];
  assign rd_ptr = ptr_q[rd_set];
endmodule

// File: rtl/vs_pick.sv
// Combinational choice of victim way and next set state.
module vs_pick
  import vs_pkg::*;
#(
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  vs_kind_e         kind,
  input  logic [WAY_W-1:0] cnt,
  input  logic [WAY_W-1:0] ptr,
  output logic [WAY_W-1:0] way,
  output logic             refuse,
  output logic [WAY_W-1:0] nxt_cnt,
  output logic [WAY_W-1:0] nxt_ptr
);
  localparam logic [WAY_W-1:0] TopWay  = WAY_W'(NUM_WAYS - 1);
  localparam logic [WAY_W-1:0] LockCap = WAY_W'(MAX_LOCK);

  logic [WAY_W-1:0] eff_ptr;

  always_comb begin
    eff_ptr = (ptr < cnt) ? cnt : ptr;
    refuse  = 1'b0;
    nxt_cnt = cnt;
    nxt_ptr = ptr;
    way     = eff_ptr;
    if (kind == VS_LOCK) begin
      way = cnt;
      if (cnt >= LockCap) begin
        refuse = 1'b1;
      end else begin
        nxt_cnt = cnt + WAY_W'(1);
      end
    end else begin
      nxt_ptr = (eff_ptr == TopWay) ? cnt : eff_ptr + WAY_W'(1);
    end
  end
endmodule

// File: rtl/vs_out_stage.sv
// One-entry result register with valid/ready hold and error pulse.
module vs_out_stage #(
  parameter int WAY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WAY_W-1:0] ld_way,
  input  logic             ld_lock,
  input  logic             ld_err,
  output logic             can_load,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WAY_W-1:0] out_way,
  output logic             out_lock,
  output logic             out_err
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_way   <= '0;
      out_lock  <= 1'b0;
    end else begin
      out_err <= load && ld_err;
      if (load) begin
        out_valid <= !ld_err;
        if (!ld_err) begin
          out_way  <= ld_way;
          out_lock <= ld_lock;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import vs_pkg::*;
#(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inval,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_lock,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_lock,
  output logic             lock_err
);
  logic             can_load;
  logic             accept;
  logic [WAY_W-1:0] cur_cnt, cur_ptr;
  logic [WAY_W-1:0] pick_way, nxt_cnt, nxt_ptr;
  logic             refuse;
  vs_kind_e         kind;

  assign kind      = vs_kind_e'(req_lock);
  assign req_ready = !inval && can_load;
  assign accept    = req_valid && req_ready;

  vs_state_table #(.NUM_SETS(NUM_SETS), .WAY_W(WAY_W)) u_table (
    .clk(clk), .rst(rst), .clear(inval),
    .rd_set(req_set), .rd_cnt(cur_cnt), .rd_ptr(cur_ptr),
    .wr_en(accept && !refuse), .wr_set(req_set),
    .wr_cnt(nxt_cnt), .wr_ptr(nxt_ptr)
  );

  vs_pick #(.NUM_WAYS(NUM_WAYS), .MAX_LOCK(MAX_LOCK)) u_pick (
    .kind(kind), .cnt(cur_cnt), .ptr(cur_ptr),
    .way(pick_way), .refuse(refuse), .nxt_cnt(nxt_cnt), .nxt_ptr(nxt_ptr)
  );

  vs_out_stage #(.WAY_W(WAY_W)) u_out (
    .clk(clk), .rst(rst), .load(accept),
    .ld_way(pick_way), .ld_lock(req_lock), .ld_err(refuse),
    .can_load(can_load), .out_valid(vic_valid), .out_ready(vic_ready),
    .out_way(vic_way), .out_lock(vic_lock), .out_err(lock_err)
  );
endmodule

// File: rtl/vs_checker.sv
module vs_checker #(
  parameter int MAX_LOCK = 28,
  parameter int WAY_W    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             inval,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_lock,
  input logic             vic_valid,
  input logic             vic_ready,
  input logic [WAY_W-1:0] vic_way,
  input logic             vic_lock,
  input logic             lock_err
);
  a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
    vic_valid && !vic_ready |=> vic_valid && $stable(vic_way) && $stable(vic_lock));

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> vic_valid ^ lock_err);

  a_r9_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !lock_err);

  a_r3_lock_way_bound: assert property (@(posedge clk) disable iff (rst)
    vic_valid && vic_lock |-> vic_way < WAY_W'(MAX_LOCK));

  a_r3_err_from_lock: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_lock |=> !lock_err);

  a_r8_inval_no_result: assert property (@(posedge clk) disable iff (rst)
    inval && !vic_valid |=> !vic_valid && !lock_err);
endmodule

bind victim_sel vs_checker #(.MAX_LOCK(MAX_LOCK), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst(rst), .inval(inval), .req_valid(req_valid),
  .req_ready(req_ready), .req_lock(req_lock), .vic_valid(vic_valid),
  .vic_ready(vic_ready), .vic_way(vic_way), .vic_lock(vic_lock),
  .lock_err(lock_err)
);

// File: tb/victim_sel_test.sv
`timescale 1ns/1ps
module victim_sel_test;
  localparam int SETS = 32;
  localparam int WAYS = 32;
  localparam int MAXL = 28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inval = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [4:0] req_set = '0;
  logic       req_lock = 1'b0;
  logic       vic_valid;
  logic       vic_ready = 1'b1;
  logic [4:0] vic_way;
  logic       vic_lock;
  logic       lock_err;

  always #4 clk = ~clk;

  victim_sel uut (
    .clk(clk), .rst(rst), .inval(inval), .req_valid(req_valid),
    .req_ready(req_ready), .req_set(req_set), .req_lock(req_lock),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_way(vic_way),
    .vic_lock(vic_lock), .lock_err(lock_err)
  );

  typedef struct {
    bit    err;
    int    way;
    bit    lk;
    string tag;
  } item_t;

  item_t q[$];
  int    lc[SETS];
  int    pt[SETS];
  int    checks = 0;
  int    fails  = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(int s, bit lk, string tag);
    item_t it;
    int l;
    int p;
    l = lc[s];
    p = pt[s];
    it.err = 1'b0;
    it.way = 0;
    it.lk  = lk;
    it.tag = tag;
    if (lk) begin
      if (l >= MAXL) it.err = 1'b1;
      else begin
        it.way = l;
        lc[s]  = l + 1;
      end
    end else begin
      if (p < l) p = l;
      it.way = p;
      pt[s]  = (p == WAYS - 1) ? l : p + 1;
    end
    q.push_back(it);
    @(negedge clk);
    req_set   = 5'(s);
    req_lock  = lk;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Monitor: compare every produced result against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (vic_valid && vic_ready) begin
        if (q.size() == 0) check(1'b0, "R9 unexpected result", vic_way, -1);
        else begin
          item_t e;
          e = q.pop_front();
          check(!e.err, {e.tag, " expected lock_err"}, 0, 1);
          check(int'(vic_way) == e.way, {e.tag, " way"}, int'(vic_way), e.way);
          check(vic_lock == e.lk, {e.tag, " R11 vic_lock"}, int'(vic_lock), int'(e.lk));
        end
      end
      if (lock_err) begin
        if (q.size() == 0) check(1'b0, "R9 unexpected lock_err", 1, 0);
        else begin
          item_t e;
          e = q.pop_front();
          check(e.err, {e.tag, " R3 lock_err"}, 1, int'(e.err));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < SETS; i++) begin
      lc[i] = 0;
      pt[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(vic_valid == 1'b0, "R1 vic_valid", int'(vic_valid), 0);
    check(lock_err == 1'b0, "R1 lock_err", int'(lock_err), 0);
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);

    // R1/R4: unpinned set rotates through all ways and wraps to 0
    for (int i = 0; i < 33; i++) send(3, 1'b0, "R4 plain rotate");

    // R2: successive locks return 0..7; R6/R5: fills skip to 8 and wrap to 8
    for (int i = 0; i < 8; i++) send(5, 1'b1, "R2 lock order");
    for (int i = 0; i < 25; i++) send(5, 1'b0, "R6/R5 locked set fill");

    // R3: lock limit, refusal leaves state unchanged
    for (int i = 0; i < 30; i++) send(7, 1'b1, "R3 lock to limit");
    for (int i = 0; i < 5; i++) send(7, 1'b0, "R3 R5 fill above limit");
    send(7, 1'b1, "R3 refused again");

    // R7: other sets untouched by previous traffic
    send(3, 1'b0, "R7 set 3 resumes");
    send(0, 1'b1, "R7 set 0 first lock");
    send(0, 1'b0, "R7 set 0 fill");

    // R6: pins added after fills push pointer up
    for (int i = 0; i < 5; i++) send(3, 1'b1, "R2 late locks");
    send(3, 1'b0, "R6 pointer repaired");
    send(3, 1'b0, "R6 pointer continues");

    // R10: back-pressure holds the result and blocks requests
    @(posedge clk);
    #1 vic_ready = 1'b0;
    send(9, 1'b0, "R10 held result");
    @(negedge clk);
    check(vic_valid == 1'b1, "R9 result one cycle after accept", int'(vic_valid), 1);
    for (int i = 0; i < 3; i++) begin
      check(req_ready == 1'b0, "R10 req_ready low while held", int'(req_ready), 0);
      check(vic_valid && vic_way == 5'd0, "R10 held way", int'(vic_way), 0);
      @(negedge clk);
    end
    @(posedge clk);
    #1 vic_ready = 1'b1;
    repeat (2) @(posedge clk);

    // R8: invalidate beats a pending request and clears all state
    #1;
    inval     = 1'b1;
    req_set   = 5'd5;
    req_lock  = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, "R8 req_ready during inval", int'(req_ready), 0);
    @(posedge clk);
    #1;
    inval     = 1'b0;
    req_valid = 1'b0;
    for (int i = 0; i < SETS; i++) begin
      lc[i] = 0;
      pt[i] = 0;
    end
    send(5, 1'b0, "R8 pointer cleared");
    send(7, 1'b1, "R8 locks cleared");
    send(7, 1'b0, "R8 fill after clear");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0, "R9 all results delivered", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule